// File: doc/BRIEF.md
# Lane-Replicated Carry-Less Multiplier

This block forms the polynomial product over GF(2) of two 64-bit quadwords. Partial products are combined by XOR, so no carries propagate. Each 128-bit lane of operand bus A and operand bus B holds two quadwords. A control byte decides which half of each operand enters the multiplier. The block returns the full 128-bit polynomial product for every lane.

The unit is replicated across 1, 2 or 4 independent 128-bit lanes, chosen by a parameter. All lanes share the control byte. A lane only ever reads its own slice of the operand buses and writes its own slice of the result bus. Lane 0 occupies the least significant 128 bits.

The datapath is a two-stage registered pipeline that accepts a new operation on every cycle. There is no backpressure. Field reduction and byte ordering are left to the surrounding logic.

Top module: `clmul_lanes`

## Requirements
- R1: Control bit 0 selects the quadword of operand A in every lane: 0 takes bits [63:0] of the lane and 1 takes bits [127:64].
- R2: Control bit 4 selects the quadword of operand B in every lane, in the same way as control bit 0 does for operand A.
- R3: Control bits 7:5 and 3:1 have no effect on the result.
- R4: For the selected quadwords a and b, result bit k of a lane is the XOR, over all i + j = k, of (a[i] AND b[j]), for k from 0 to 127.
- R5: Bit 127 of every lane result is zero whenever out_valid is high.
- R6: Lane n, which is bits [128n+127:128n], is computed only from bits [128n+127:128n] of opnd_a and opnd_b, and its result is placed in the same bit range of prod_out.
- R7: out_valid is high exactly two clock cycles after in_valid was high. The product on prod_out belongs to the operands that were presented in that cycle.
- R8: A new operation may be presented on every cycle, and back-to-back operations come out back to back in issue order.
- R9: While rst is high at a clock edge, out_valid and the internal stage-valid bit are cleared by that edge. Any operations already in flight are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and control are valid this cycle |
| ctrl | input | 8 | Control byte: bit 0 picks the A half, bit 4 picks the B half |
| opnd_a | input | LANES*128 | Operand A, one 128-bit lane per slice |
| opnd_b | input | LANES*128 | Operand B, one 128-bit lane per slice |
| out_valid | output | 1 | prod_out holds a result |
| prod_out | output | LANES*128 | One 128-bit carry-less product per lane |

## Verification
Several properties are checked on every cycle:
- the two-cycle valid timing and its clearing by reset;
- the half selection into the first pipeline register;
- bit 0 of each result against the AND of the low bits of the registered operands;
- the zero top bit of every valid lane result.

The full product value can only be shown by the bench's scenarios. These compare every lane against a bit-serial shift-and-XOR model and cover:
- all four selection combinations;
- random settings of the unused control bits;
- all-ones and single-bit operands;
- idle gaps in the stream;
- a reset that arrives while the pipeline is full.

// File: rtl/clmul_pkg.sv
package clmul_pkg;
  localparam int QW     = 64;
  localparam int LANE_W = 2 * QW;

  function automatic logic [QW-1:0] rev_qw(input logic [QW-1:0] v);
    logic [QW-1:0] r;
    for (int i = 0; i < QW; i++) r[i] = v[QW-1-i];
    return r;
  endfunction

  // low quadword of the GF(2) product: bit k gathers all pairs i + j = k
  function automatic logic [QW-1:0] xmul_low(input logic [QW-1:0] a, input logic [QW-1:0] b);
    logic [QW-1:0] r;
    r = '0;
    for (int k = 0; k < QW; k++)
      for (int i = 0; i <= k; i++)
        r[k] = r[k] ^ (a[i] & b[k-i]);
    return r;
  endfunction

  // high quadword obtained by running the low-half network on reversed operands
  function automatic logic [QW-1:0] xmul_high(input logic [QW-1:0] a, input logic [QW-1:0] b);
    return rev_qw(xmul_low(rev_qw(a), rev_qw(b))) >> 1;
  endfunction
endpackage

// File: rtl/clmul_opsel.sv
module clmul_opsel
  import clmul_pkg::*;
(
  input  logic [LANE_W-1:0] lane_word,
  input  logic              pick_hi,
  output logic [QW-1:0]     half
);
  always_comb half = pick_hi ? lane_word[LANE_W-1:QW] : lane_word[QW-1:0];
endmodule

// File: rtl/clmul_core.sv
module clmul_core
  import clmul_pkg::*;
(
  input  logic [QW-1:0]     mul_a,
  input  logic [QW-1:0]     mul_b,
  output logic [LANE_W-1:0] mul_p
);
  logic [QW-1:0] p_lo;
  logic [QW-1:0] p_hi;
  always_comb begin
    p_lo  = xmul_low(mul_a, mul_b);
    p_hi  = xmul_high(mul_a, mul_b);
    mul_p = {p_hi, p_lo};
  end
endmodule

// File: rtl/clmul_lane.sv
module clmul_lane
  import clmul_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              stg1_valid,
  input  logic              stg2_valid,
  input  logic              sel_a_hi,
  input  logic              sel_b_hi,
  input  logic [LANE_W-1:0] lane_a,
  input  logic [LANE_W-1:0] lane_b,
  output logic [LANE_W-1:0] lane_p
);
  logic [QW-1:0]     pick_a, pick_b;
  logic [QW-1:0]     a_q, b_q;
  logic [LANE_W-1:0] prod_comb;
  logic [LANE_W-1:0] prod_q;

  clmul_opsel u_sel_a (.lane_word(lane_a), .pick_hi(sel_a_hi), .half(pick_a));
  clmul_opsel u_sel_b (.lane_word(lane_b), .pick_hi(sel_b_hi), .half(pick_b));

  // stage 1: selected quadwords, loaded only for a valid operation
  always_ff @(posedge clk) begin
    if (in_valid) begin
      a_q <= pick_a;
      b_q <= pick_b;
    end
  end

  clmul_core u_core (.mul_a(a_q), .mul_b(b_q), .mul_p(prod_comb));

  // stage 2: full product
  always_ff @(posedge clk) begin
    if (stg1_valid) prod_q <= prod_comb;
  end

  assign lane_p = prod_q;

  assert_sel_a_R1: assert property (@(posedge clk) disable iff (rst)
    stg1_valid |-> a_q == $past(sel_a_hi ? lane_a[LANE_W-1:QW] : lane_a[QW-1:0]));
  assert_sel_b_R2: assert property (@(posedge clk) disable iff (rst)
    stg1_valid |-> b_q == $past(sel_b_hi ? lane_b[LANE_W-1:QW] : lane_b[QW-1:0]));
  assert_bit0_R4: assert property (@(posedge clk) disable iff (rst)
    stg2_valid |-> prod_q[0] == $past(a_q[0] & b_q[0]));
  assert_top_zero_R5: assert property (@(posedge clk) disable iff (rst)
    stg2_valid |-> !prod_q[LANE_W-1]);
endmodule

// File: rtl/clmul_lanes.sv
module clmul_lanes
  import clmul_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [7:0]              ctrl,
  input  logic [LANES*LANE_W-1:0] opnd_a,
  input  logic [LANES*LANE_W-1:0] opnd_b,
  output logic                    out_valid,
  output logic [LANES*LANE_W-1:0] prod_out
);
  localparam int BUS_W = LANES * LANE_W;

  logic stg1_valid;
  logic stg2_valid;
  logic sel_a_hi, sel_b_hi;
  logic ctrl_unused;

  assign sel_a_hi    = ctrl[0];
  assign sel_b_hi    = ctrl[4];
  assign ctrl_unused = ^{ctrl[7:5], ctrl[3:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      stg1_valid <= 1'b0;
      stg2_valid <= 1'b0;
    end else begin
      stg1_valid <= in_valid;
      stg2_valid <= stg1_valid;
    end
  end

  assign out_valid = stg2_valid;

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    clmul_lane u_lane (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .stg1_valid(stg1_valid),
      .stg2_valid(stg2_valid),
      .sel_a_hi  (sel_a_hi),
      .sel_b_hi  (sel_b_hi),
      .lane_a    (opnd_a[n*LANE_W +: LANE_W]),
      .lane_b    (opnd_b[n*LANE_W +: LANE_W]),
      .lane_p    (prod_out[n*LANE_W +: LANE_W])
    );
  end

  initial begin
    assert_lane_count_R6: assert (LANES == 1 || LANES == 2 || LANES == 4)
      else $error("LANES must be 1, 2 or 4, got %0d (BUS_W %0d)", LANES, BUS_W);
  end

  assert_stage1_R7: assert property (@(posedge clk) disable iff (rst)
    stg1_valid == $past(in_valid));
  assert_out_valid_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(stg1_valid));
  assert_reset_clear_R9: assert property (@(posedge clk)
    $past(rst) |-> !out_valid && !stg1_valid);
endmodule

// File: tb/clmul_lanes_bench.sv
module clmul_lanes_bench;
  localparam int LANES = 2;
  localparam int LW    = 128;
  localparam int BW    = LANES * LW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [7:0]    ctrl = '0;
  logic [BW-1:0] opnd_a = '0;
  logic [BW-1:0] opnd_b = '0;
  logic          out_valid;
  logic [BW-1:0] prod_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic          h1_v = 1'b0, h2_v = 1'b0;
  logic [BW-1:0] h1_p = '0, h2_p = '0;
  string         h1_t = "", h2_t = "";

  always #4 clk = ~clk;

  clmul_lanes #(.LANES(LANES)) u_clmul_lanes (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ctrl(ctrl),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .prod_out(prod_out)
  );

  // bit-serial reference: shift A left, XOR in wherever B has a one
  function automatic logic [127:0] serial_mul(input logic [63:0] a, input logic [63:0] b);
    logic [127:0] acc = '0;
    logic [127:0] sh  = {64'd0, a};
    for (int i = 0; i < 64; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh << 1;
    end
    return acc;
  endfunction

  function automatic logic [BW-1:0] expect_vec(input logic [7:0] c,
                                               input logic [BW-1:0] a,
                                               input logic [BW-1:0] b);
    logic [BW-1:0] r;
    for (int n = 0; n < LANES; n++) begin
      logic [63:0] qa = c[0] ? a[n*LW+64 +: 64] : a[n*LW +: 64];
      logic [63:0] qb = c[4] ? b[n*LW+64 +: 64] : b[n*LW +: 64];
      r[n*LW +: LW] = serial_mul(qa, qb);
    end
    return r;
  endfunction

  task automatic check_out();
    checks++;
    if (out_valid !== h2_v) begin
      fails++;
      $display("FAIL R7 out_valid actual %b expected %b", out_valid, h2_v);
    end
    if (h2_v) begin
      for (int n = 0; n < LANES; n++) begin
        checks++;
        if (prod_out[n*LW +: LW] !== h2_p[n*LW +: LW]) begin
          fails++;
          $display("FAIL %s lane %0d actual %h expected %h", h2_t, n,
                   prod_out[n*LW +: LW], h2_p[n*LW +: LW]);
        end
        checks++;
        if (prod_out[n*LW+LW-1] !== 1'b0) begin
          fails++;
          $display("FAIL R5 lane %0d top bit actual %b expected 0", n, prod_out[n*LW+LW-1]);
        end
      end
    end
  endtask

  // called just after a falling edge
  task automatic step(input logic v, input logic [7:0] c,
                      input logic [BW-1:0] a, input logic [BW-1:0] b, input string tag);
    check_out();
    h2_v = h1_v; h2_p = h1_p; h2_t = h1_t;
    h1_v = v;    h1_p = expect_vec(c, a, b); h1_t = tag;
    in_valid = v; ctrl = c; opnd_a = a; opnd_b = b;
    @(negedge clk);
  endtask

  function automatic logic [BW-1:0] rnd_bus();
    logic [BW-1:0] r;
    for (int w = 0; w < BW / 32; w++) r[w*32 +: 32] = $urandom();
    return r;
  endfunction

  task automatic reset_check(input string why);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R9 %s out_valid actual %b expected 0", why, out_valid);
    end
    @(negedge clk);
    h1_v = 1'b0; h2_v = 1'b0;
    rst = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240517));
    repeat (2) @(negedge clk);
    reset_check("initial");

    // directed corners, all four selection combinations (R1, R2)
    for (int s = 0; s < 4; s++) begin
      logic [7:0] c = {3'b000, s[1], 3'b000, s[0]};
      step(1, c, {BW{1'b1}}, {BW{1'b1}}, "R1/R2/R4 all-ones");
      step(1, c, {LANES{64'd1, 64'd1}}, {LANES{64'd1, 64'd1}}, "R4 bit0");
      step(1, c, {LANES{64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000}},
               {LANES{64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000}}, "R4 bit63");
      step(1, c, {LANES{64'h8000_0000_0000_0000, 64'd1}},
               {LANES{64'd1, 64'h8000_0000_0000_0000}}, "R1/R2 mixed halves");
    end

    // lanes with distinct contents (R6)
    for (int i = 0; i < 20; i++)
      step(1, {3'b0, i[0], 3'b0, i[1]}, rnd_bus(), rnd_bus(), "R6 lane independence");

    // random stream with gaps and random unused control bits (R3, R8)
    for (int i = 0; i < 300; i++) begin
      logic v = ($urandom_range(0, 5) != 0);
      step(v, 8'($urandom()), rnd_bus(), rnd_bus(), "R3/R8 random");
    end

    // fill the pipe, then reset mid-flight (R9)
    step(1, 8'h11, rnd_bus(), rnd_bus(), "R8 prefill");
    step(1, 8'h00, rnd_bus(), rnd_bus(), "R8 prefill");
    reset_check("in flight");
    step(0, 8'h00, '0, '0, "R9 drain");
    step(0, 8'h00, '0, '0, "R9 drain");
    step(1, 8'hEE, rnd_bus(), rnd_bus(), "R3 after reset");
    step(0, 8'h00, '0, '0, "R7 flush");
    step(0, 8'h00, '0, '0, "R7 flush");
    step(0, 8'h00, '0, '0, "R7 flush");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule